// File: doc/BRIEF.md
# Six-Operand Pipelined Carry-Save Adder

This block adds six unsigned operands of equal width and returns their exact total. Reduction is done by four 3:2 carry-save rows in three levels: two rows in the first level, one in the second, and one in the third. A ripple-carry adder then merges the two vectors that remain. Each carry-save row applies the full-adder sum and majority equations independently at every bit. Each carry vector moves up one bit position before the next level takes it.

Rising-edge register ranks sit at the operand inputs and after each carry-save level, which gives four ranks in all. The final ripple-carry adder has no register. It is combinational logic driven by the last rank, so that no flops are spent where the critical path does not need them. A valid flag travels through the same ranks as the data. A new operand set can be accepted on every clock. With the default 16-bit operands the result is 19 bits wide.

Top module: `csa6_pipe_adder`

## Requirements
- R1: While rst_ni is low, valid_o is 0, and every pipeline rank is cleared without waiting for a clock edge.
- R2: When valid_o is 1, sum_o equals the arithmetic sum of the six operands of the set that produced it.
- R3: sum_o has OP_W+3 bits (19 by default) and never wraps: six operands of all ones give 6*(2^OP_W-1), which is 393210 by default.
- R4: The result of an operand set presented before rising edge k is on sum_o, with valid_o high, after rising edge k+3, that is, four edges after presentation. valid_o equals valid_i from four edges earlier.
- R5: One operand set is accepted on each clock. Consecutive sets come out on consecutive cycles, in the order they went in.
- R6: A cycle with valid_i low produces a cycle with valid_o low at the matching output position, and the sets around it are unaffected.
- R7: Every operand position carries the same weight: a single nonzero operand at any of the six positions, with the other five at zero, gives that operand's value on sum_o.
- R8: A carry ripples across the full result width. For example, 0xFFFF plus 1 plus four zeros gives 0x10000, and sets that chain carries through every level give the exact sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all ranks capture on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | The operand set on op0_i..op5_i is valid |
| op0_i | input | OP_W | Operand 0 |
| op1_i | input | OP_W | Operand 1 |
| op2_i | input | OP_W | Operand 2 |
| op3_i | input | OP_W | Operand 3 |
| op4_i | input | OP_W | Operand 4 |
| op5_i | input | OP_W | Operand 5 |
| sum_o | output | OP_W+3 | Sum of the six operands, four edges after presentation |
| valid_o | output | 1 | sum_o holds a valid result |

## Verification
The hardest case to reach from the ports is a carry that must cross the boundary between two register ranks and then ripple through the whole unregistered final adder. Directed sets produce it: all operands at maximum, a pair of 0xFFFF and 1, and patterns of alternating bits whose majority outputs chain through all three levels. These sets are fed back to back and mixed with bubble cycles and with a reset applied mid-stream. A four-deep model in the bench follows each set and its valid bit, and compares the output on the exact cycle it is due.

// File: rtl/csa6_pkg.sv
package csa6_pkg;
  localparam int unsigned NUM_OPS    = 6;
  localparam int unsigned PIPE_DEPTH = 4;
  localparam int unsigned GROWTH     = $clog2(NUM_OPS);

  function automatic int unsigned sum_width(input int unsigned op_w);
    return op_w + GROWTH;
  endfunction
endpackage

// File: rtl/csa_row.sv
// 3:2 carry-save row; carry output already shifted up one bit.
module csa_row #(
  parameter int unsigned W = 19
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] z_i,
  output logic [W-1:0] s_o,
  output logic [W-1:0] c_o
);
  assign s_o    = x_i ^ y_i ^ z_i;
  assign c_o[0] = 1'b0;

  for (genvar i = 1; i < W; i++) begin : g_maj
    assign c_o[i] = (x_i[i-1] & y_i[i-1]) | (x_i[i-1] & z_i[i-1]) | (y_i[i-1] & z_i[i-1]);
  end
endmodule

// File: rtl/pipe_rank.sv
module pipe_rank #(
  parameter int unsigned W = 19
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/rca_adder.sv
// Ripple-carry adder; the carry out of the MSB is discarded because the width already holds the full sum.
module rca_adder #(
  parameter int unsigned W = 19
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] s_o
);
  logic [W-1:0] cy;
  assign cy[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign s_o[i] = a_i[i] ^ b_i[i] ^ cy[i];
    if (i < W - 1) begin : g_cy
      assign cy[i+1] = (a_i[i] & b_i[i]) | (cy[i] & (a_i[i] ^ b_i[i]));
    end
  end
endmodule

// File: rtl/csa6_pipe_adder.sv
module csa6_pipe_adder
  import csa6_pkg::*;
#(
  parameter int unsigned OP_W = 16,
  localparam int unsigned SUM_W = OP_W + csa6_pkg::GROWTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [OP_W-1:0]  op0_i,
  input  logic [OP_W-1:0]  op1_i,
  input  logic [OP_W-1:0]  op2_i,
  input  logic [OP_W-1:0]  op3_i,
  input  logic [OP_W-1:0]  op4_i,
  input  logic [OP_W-1:0]  op5_i,
  output logic [SUM_W-1:0] sum_o,
  output logic             valid_o
);
  localparam int unsigned PAD_W = SUM_W - OP_W;

  logic [OP_W-1:0]  op_in [NUM_OPS];
  logic [SUM_W-1:0] op_q  [NUM_OPS];

  assign op_in[0] = op0_i;
  assign op_in[1] = op1_i;
  assign op_in[2] = op2_i;
  assign op_in[3] = op3_i;
  assign op_in[4] = op4_i;
  assign op_in[5] = op5_i;

  // rank 0: operand capture, zero-extended to result width
  for (genvar g = 0; g < NUM_OPS; g++) begin : g_rank0
    pipe_rank #(.W(SUM_W)) u_reg (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   ({{PAD_W{1'b0}}, op_in[g]}),
      .q_o   (op_q[g])
    );
  end

  // level 1: two rows, rank 1
  logic [SUM_W-1:0] l1_s [2];
  logic [SUM_W-1:0] l1_c [2];
  logic [SUM_W-1:0] r1_s [2];
  logic [SUM_W-1:0] r1_c [2];

  for (genvar g = 0; g < 2; g++) begin : g_lvl1
    csa_row #(.W(SUM_W)) u_row (
      .x_i(op_q[3*g]),
      .y_i(op_q[3*g+1]),
      .z_i(op_q[3*g+2]),
      .s_o(l1_s[g]),
      .c_o(l1_c[g])
    );
    pipe_rank #(.W(SUM_W)) u_s (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(l1_s[g]), .q_o(r1_s[g])
    );
    pipe_rank #(.W(SUM_W)) u_c (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(l1_c[g]), .q_o(r1_c[g])
    );
  end

  // level 2: one row on three vectors, fourth vector delayed; rank 2
  logic [SUM_W-1:0] l2_s, l2_c;
  logic [SUM_W-1:0] r2_s, r2_c, r2_pass;

  csa_row #(.W(SUM_W)) u_lvl2 (
    .x_i(r1_s[0]),
    .y_i(r1_c[0]),
    .z_i(r1_s[1]),
    .s_o(l2_s),
    .c_o(l2_c)
  );
  pipe_rank #(.W(SUM_W)) u_r2_s (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(l2_s), .q_o(r2_s)
  );
  pipe_rank #(.W(SUM_W)) u_r2_c (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(l2_c), .q_o(r2_c)
  );
  pipe_rank #(.W(SUM_W)) u_r2_pass (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(r1_c[1]), .q_o(r2_pass)
  );

  // level 3: final row, rank 3
  logic [SUM_W-1:0] l3_s, l3_c;
  logic [SUM_W-1:0] r3_s, r3_c;

  csa_row #(.W(SUM_W)) u_lvl3 (
    .x_i(r2_s),
    .y_i(r2_c),
    .z_i(r2_pass),
    .s_o(l3_s),
    .c_o(l3_c)
  );
  pipe_rank #(.W(SUM_W)) u_r3_s (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(l3_s), .q_o(r3_s)
  );
  pipe_rank #(.W(SUM_W)) u_r3_c (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(l3_c), .q_o(r3_c)
  );

  // unregistered final resolve
  rca_adder #(.W(SUM_W)) u_rca (
    .a_i(r3_s),
    .b_i(r3_c),
    .s_o(sum_o)
  );

  // valid travels alongside the data ranks
  logic [PIPE_DEPTH-1:0] vld_q;
  pipe_rank #(.W(PIPE_DEPTH)) u_vld (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({vld_q[PIPE_DEPTH-2:0], valid_i}),
    .q_o   (vld_q)
  );
  assign valid_o = vld_q[PIPE_DEPTH-1];
endmodule

// File: rtl/csa6_pipe_adder_chk.sv
module csa6_pipe_adder_chk #(
  parameter int unsigned OP_W = 16,
  localparam int unsigned SUM_W = OP_W + csa6_pkg::GROWTH
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [OP_W-1:0]  op0_i,
  input logic [OP_W-1:0]  op1_i,
  input logic [OP_W-1:0]  op2_i,
  input logic [OP_W-1:0]  op3_i,
  input logic [OP_W-1:0]  op4_i,
  input logic [OP_W-1:0]  op5_i,
  input logic [SUM_W-1:0] sum_o,
  input logic             valid_o
);
  localparam logic [SUM_W-1:0] MAX_SUM = SUM_W'(6) * SUM_W'((2**OP_W) - 1);

  logic [SUM_W-1:0] ref_in;
  assign ref_in = SUM_W'(op0_i) + SUM_W'(op1_i) + SUM_W'(op2_i)
                + SUM_W'(op3_i) + SUM_W'(op4_i) + SUM_W'(op5_i);

  // edges since reset, saturating; gates the four-deep history checks
  logic [2:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           age_q <= '0;
    else if (age_q < 3'd4) age_q <= age_q + 3'd1;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) AST_RESET_CLEAR: assert (valid_o == 1'b0); // R1
  end

  AST_SUM_EXACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 3'd4 && valid_o) |-> sum_o == $past(ref_in, 4)); // R2

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> sum_o <= MAX_SUM); // R3

  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 3'd4) |-> valid_o == $past(valid_i, 4)); // R4

  AST_EARLY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q < 3'd4) |-> !valid_o); // R6
endmodule

bind csa6_pipe_adder csa6_pipe_adder_chk #(.OP_W(OP_W)) u_chk (.*);

// File: tb/csa6_pipe_adder_bench.sv
`timescale 1ns/1ps
module csa6_pipe_adder_bench;
  localparam int unsigned OP_W  = 16;
  localparam int unsigned SUM_W = OP_W + 3;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             valid_i = 1'b0;
  logic [OP_W-1:0]  ops [6];
  logic [SUM_W-1:0] sum_o;
  logic             valid_o;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  logic [31:0] seed = 32'h1234_5678;

  // bench model: four slots, slot 3 is due at the next compare
  logic [SUM_W-1:0] h_sum [4];
  logic             h_vld [4];
  string            h_tag [4];

  always #5 clk_i = ~clk_i;

  csa6_pipe_adder #(.OP_W(OP_W)) u_csa6_pipe_adder (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .op0_i  (ops[0]),
    .op1_i  (ops[1]),
    .op2_i  (ops[2]),
    .op3_i  (ops[3]),
    .op4_i  (ops[4]),
    .op5_i  (ops[5]),
    .sum_o  (sum_o),
    .valid_o(valid_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] next_rand(input logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13;
    x ^= x >> 17;
    x ^= x << 5;
    return x;
  endfunction

  function automatic logic [SUM_W-1:0] ref_sum(input logic [OP_W-1:0] o [6]);
    logic [SUM_W-1:0] acc = '0;
    for (int i = 0; i < 6; i++) acc += SUM_W'(o[i]);
    return acc;
  endfunction

  task automatic clear_model();
    for (int i = 0; i < 4; i++) begin
      h_sum[i] = '0;
      h_vld[i] = 1'b0;
      h_tag[i] = "R4";
    end
  endtask

  // one cycle: compare what is due, then present a new set
  task automatic step(input logic v, input logic [OP_W-1:0] o [6], input string tag);
    @(negedge clk_i);
    check({h_tag[3], "/valid"}, 32'(valid_o), 32'(h_vld[3]));
    if (h_vld[3]) check(h_tag[3], 32'(sum_o), 32'(h_sum[3]));
    for (int i = 3; i > 0; i--) begin
      h_sum[i] = h_sum[i-1];
      h_vld[i] = h_vld[i-1];
      h_tag[i] = h_tag[i-1];
    end
    for (int i = 0; i < 6; i++) ops[i] = o[i];
    valid_i  = v;
    h_sum[0] = ref_sum(o);
    h_vld[0] = v;
    h_tag[0] = tag;
  endtask

  task automatic flush();
    logic [OP_W-1:0] z [6];
    for (int i = 0; i < 6; i++) z[i] = '0;
    for (int k = 0; k < 5; k++) step(1'b0, z, "R6");
  endtask

  task automatic t_reset();
    clear_model();
    for (int i = 0; i < 6; i++) ops[i] = '0;
    rst_ni = 1'b0;
    #12;
    check("R1 reset valid", 32'(valid_o), 32'd0);
    check("R1 reset sum", 32'(sum_o), 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_zero_and_max();
    logic [OP_W-1:0] o [6];
    for (int i = 0; i < 6; i++) o[i] = '0;
    step(1'b1, o, "R2 zero");
    for (int i = 0; i < 6; i++) o[i] = '1;
    step(1'b1, o, "R3 all-max");
    flush();
  endtask

  task automatic t_latency();
    logic [OP_W-1:0] o [6];
    for (int i = 0; i < 6; i++) o[i] = OP_W'(i + 1);
    step(1'b1, o, "R4 single");
    for (int i = 0; i < 6; i++) o[i] = '0;
    step(1'b0, o, "R4");
    step(1'b0, o, "R4");
    step(1'b0, o, "R4");
    // set is due at this compare: exactly four edges after presentation
    @(negedge clk_i);
    check("R4 valid at edge 4", 32'(valid_o), 32'd1);
    check("R4 sum at edge 4", 32'(sum_o), 32'd21);
    for (int i = 3; i > 0; i--) begin
      h_sum[i] = h_sum[i-1]; h_vld[i] = h_vld[i-1]; h_tag[i] = h_tag[i-1];
    end
    valid_i = 1'b0;
    h_vld[0] = 1'b0; h_sum[0] = '0; h_tag[0] = "R4";
    flush();
  endtask

  task automatic t_onehot();
    logic [OP_W-1:0] o [6];
    for (int p = 0; p < 6; p++) begin
      for (int i = 0; i < 6; i++) o[i] = '0;
      o[p] = OP_W'(16'h1001 << p);
      step(1'b1, o, "R7 position");
    end
    flush();
  endtask

  task automatic t_carry();
    logic [OP_W-1:0] o [6];
    for (int i = 0; i < 6; i++) o[i] = '0;
    o[0] = 16'hFFFF; o[1] = 16'h0001;
    step(1'b1, o, "R8 0xFFFF+1");
    for (int i = 0; i < 6; i++) o[i] = (i % 2) ? 16'hAAAA : 16'h5555;
    step(1'b1, o, "R8 alt bits");
    for (int i = 0; i < 6; i++) o[i] = 16'h7FFF;
    step(1'b1, o, "R8 chained");
    o[5] = 16'h0001;
    for (int i = 0; i < 5; i++) o[i] = 16'hFFFF;
    step(1'b1, o, "R8 full ripple");
    flush();
  endtask

  task automatic t_stream();
    logic [OP_W-1:0] o [6];
    for (int k = 0; k < 40; k++) begin
      for (int i = 0; i < 6; i++) begin
        seed = next_rand(seed);
        o[i] = seed[OP_W-1:0];
      end
      step(1'b1, o, "R5 stream");
    end
    flush();
  endtask

  task automatic t_bubbles();
    logic [OP_W-1:0] o [6];
    for (int k = 0; k < 30; k++) begin
      for (int i = 0; i < 6; i++) begin
        seed = next_rand(seed);
        o[i] = seed[OP_W-1:0];
      end
      seed = next_rand(seed);
      step(seed[3] | seed[7], o, "R6 bubbles");
    end
    flush();
  endtask

  task automatic t_mid_reset();
    logic [OP_W-1:0] o [6];
    for (int i = 0; i < 6; i++) o[i] = 16'h0F0F;
    step(1'b1, o, "R1 pre");
    step(1'b1, o, "R1 pre");
    #2;
    rst_ni = 1'b0;
    #1;
    check("R1 async clear", 32'(valid_o), 32'd0);
    check("R1 async sum", 32'(sum_o), 32'd0);
    valid_i = 1'b0;
    clear_model();
    @(negedge clk_i);
    rst_ni = 1'b1;
    flush();
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_zero_and_max();
    t_latency();
    t_onehot();
    t_carry();
    t_stream();
    t_bubbles();
    t_mid_reset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule